// File: doc/BRIEF.md
# Flag-Setting Data ALU with Decimal Add

This block is the purely combinational arithmetic and logic unit of a small 16-bit processor core. It takes a source operand, a destination operand, a 4-bit operation code, a byte/word select and the incoming carry flag. From these it produces the result, a strobe that says whether the result is written back, a strobe that says whether the status flags are updated, and new values for the negative, zero, carry and overflow flags. Two-operand operations read both operands. One-operand operations (rotates, swap, sign extend) act on the destination operand only.

A single binary adder serves add, add-with-carry, subtract, subtract-with-carry and compare. Subtraction is done by inverting the source and choosing the carry-in. A separate chain of BCD digit adders handles decimal add. In byte mode every operation uses only the low eight bits of its operands and returns a result whose upper byte is zero, and the flags are taken from bit 7. Swap-bytes and sign-extend always work on the full word.

Top module: `alu_flag_core`

## Requirements
- R1: Operation codes are 0 ADD, 1 ADDC, 2 SUB, 3 SUBC, 4 CMP, 5 DADD, 6 AND, 7 BIT, 8 BIC, 9 BIS, 10 XOR, 11 MOV, 12 RRA, 13 RRC, 14 SWPB, 15 SXT. writeEn is 0 for CMP and BIT and 1 for every other code, while result still carries the computed value.
- R2: ADD gives dst+src, ADDC gives dst+src+C, SUB and CMP give dst+(NOT src)+1, and SUBC gives dst+(NOT src)+C, where C is carryIn.
- R3: DADD adds src, dst and carryIn as packed BCD digits (valid digits assumed). Each digit above 9 is corrected by adding 6 and passes a carry to the next digit. cFlag is the carry out of the top digit of the active width (digit 1 in byte mode, digit 3 in word mode), and vFlag is 0.
- R4: AND and BIT give src AND dst, BIC gives (NOT src) AND dst, BIS gives src OR dst, XOR gives src XOR dst, and MOV gives src.
- R5: RRA shifts dst right one place and keeps its sign bit. RRC shifts dst right and puts carryIn into the top bit. In both cases cFlag is the bit shifted out of dst bit 0, and vFlag is 0.
- R6: SWPB exchanges the two bytes of dst. SXT copies dst bit 7 into bits 15..8. Both ignore byteSel and always work on the full word.
- R7: With byteSel=1, every operation except SWPB and SXT uses only bits 7..0 of its operands, and result bits 15..8 are 0.
- R8: When flags are updated, nFlag is the top bit of the active width (bit 7 in byte mode, bit 15 in word mode) and zFlag is 1 exactly when the active result is zero.
- R9: For ADD, ADDC, SUB, SUBC and CMP, cFlag is the carry out of the active width. vFlag is 1 when both adder inputs (dst and the possibly inverted src) have the same sign and the result's sign differs from it.
- R10: For AND, BIT, XOR and SXT, vFlag is 0 and cFlag is the inverse of zFlag.
- R11: flagEn is 0 for BIC, BIS, MOV and SWPB, and 1 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcIn | input | 16 | Source operand |
| dstIn | input | 16 | Destination operand (the single operand of one-operand codes) |
| opSel | input | 4 | Operation code, as listed in R1 |
| byteSel | input | 1 | 1 selects byte width, 0 selects word width |
| carryIn | input | 1 | Current carry flag |
| result | output | 16 | Computed result |
| writeEn | output | 1 | Result should be written to the destination |
| flagEn | output | 1 | Flag outputs should be loaded into the status register |
| nFlag | output | 1 | Negative flag |
| zFlag | output | 1 | Zero flag |
| cFlag | output | 1 | Carry flag |
| vFlag | output | 1 | Overflow flag |

## Verification
The block holds no state, so an error in its decoded control strobes or a wrong operand width shows on the ports in the same evaluation as the inputs that cause it. A wrong carry select or a missing source inversion shows up as a result that is off by one, or as a wrong carry or overflow flag, for the affected codes. A broken BCD correction shows up as a non-decimal digit or a wrong digit carry. Bad byte-lane masking shows up as nonzero upper result bits, or as flags read from bit 15 instead of bit 7. Decimal add is checked against every pair of two-digit BCD operands with both carry-in values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_MOV  = 4'd11,
    OP_RRA  = 4'd12,
    OP_RRC  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    RES_SUM, RES_BCD, RES_AND, RES_BIC, RES_BIS, RES_XOR,
    RES_SRC, RES_RRA, RES_RRC, RES_SWP, RES_SXT
  } resSel_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_FLAG, CIN_ONE
  } cinSel_e;

  typedef enum logic [1:0] {
    CY_SUM, CY_BCD, CY_NOTZ, CY_LSB
  } cySel_e;

  typedef struct packed {
    resSel_e resSel;
    logic    invSrc;
    cinSel_e cinSel;
    cySel_e  cySel;
    logic    arithV;
    logic    forceWord;
    logic    writeEn;
    logic    flagEn;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.resSel    = RES_SUM;
    ctrl.invSrc    = 1'b0;
    ctrl.cinSel    = CIN_ZERO;
    ctrl.cySel     = CY_NOTZ;
    ctrl.arithV    = 1'b0;
    ctrl.forceWord = 1'b0;
    ctrl.writeEn   = 1'b1;
    ctrl.flagEn    = 1'b1;
    case (opSel)
      OP_ADD:  begin ctrl.cySel = CY_SUM; ctrl.arithV = 1'b1; end
      OP_ADDC: begin ctrl.cySel = CY_SUM; ctrl.arithV = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_SUB: begin
        ctrl.cySel = CY_SUM; ctrl.arithV = 1'b1;
        ctrl.invSrc = 1'b1;  ctrl.cinSel = CIN_ONE;
      end
      OP_SUBC: begin
        ctrl.cySel = CY_SUM; ctrl.arithV = 1'b1;
        ctrl.invSrc = 1'b1;  ctrl.cinSel = CIN_FLAG;
      end
      OP_CMP: begin
        ctrl.cySel = CY_SUM; ctrl.arithV = 1'b1;
        ctrl.invSrc = 1'b1;  ctrl.cinSel = CIN_ONE;
        ctrl.writeEn = 1'b0;
      end
      OP_DADD: begin ctrl.resSel = RES_BCD; ctrl.cySel = CY_BCD; ctrl.cinSel = CIN_FLAG; end
      OP_AND:  ctrl.resSel = RES_AND;
      OP_BIT:  begin ctrl.resSel = RES_AND; ctrl.writeEn = 1'b0; end
      OP_BIC:  begin ctrl.resSel = RES_BIC; ctrl.flagEn = 1'b0; end
      OP_BIS:  begin ctrl.resSel = RES_BIS; ctrl.flagEn = 1'b0; end
      OP_XOR:  ctrl.resSel = RES_XOR;
      OP_MOV:  begin ctrl.resSel = RES_SRC; ctrl.flagEn = 1'b0; end
      OP_RRA:  begin ctrl.resSel = RES_RRA; ctrl.cySel = CY_LSB; end
      OP_RRC:  begin ctrl.resSel = RES_RRC; ctrl.cySel = CY_LSB; end
      OP_SWPB: begin ctrl.resSel = RES_SWP; ctrl.forceWord = 1'b1; ctrl.flagEn = 1'b0; end
      OP_SXT:  begin ctrl.resSel = RES_SXT; ctrl.forceWord = 1'b1; end
      default: ctrl.resSel = RES_SUM;
    endcase
  end

endmodule

// File: rtl/alu_bcd_chain.sv
module alu_bcd_chain #(
  parameter int Digits = 4
) (
  input  logic [4*Digits-1:0] aIn,
  input  logic [4*Digits-1:0] bIn,
  input  logic                cIn,
  output logic [4*Digits-1:0] sumOut,
  output logic [Digits-1:0]   digitCarry
);

  logic [Digits:0] chain;
  assign chain[0] = cIn;

  for (genvar g = 0; g < Digits; g++) begin : gDigit
    logic [4:0] rawSum;
    logic       adjust;
    always_comb begin
      rawSum = {1'b0, aIn[4*g+3:4*g]} + {1'b0, bIn[4*g+3:4*g]} + {4'b0, chain[g]};
      adjust = rawSum > 5'd9;
    end
    assign sumOut[4*g+3:4*g] = adjust ? (rawSum[3:0] + 4'd6) : rawSum[3:0];
    assign chain[g+1]        = adjust;
    assign digitCarry[g]     = adjust;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DataWidth = 16
) (
  input  aluCtrl_t             ctrl,
  input  logic [DataWidth-1:0] srcIn,
  input  logic [DataWidth-1:0] dstIn,
  input  logic                 byteSel,
  input  logic                 carryIn,
  output logic [DataWidth-1:0] result,
  output logic                 nFlag,
  output logic                 zFlag,
  output logic                 cFlag,
  output logic                 vFlag
);

  localparam int Half   = DataWidth / 2;
  localparam int Digits = DataWidth / 4;

  logic                 narrow;
  logic [DataWidth-1:0] bOp;
  logic                 cinBit;
  logic [DataWidth:0]   sumFull;
  logic [Half:0]        sumLow;
  logic [DataWidth-1:0] bcdSum;
  logic [Digits-1:0]    bcdCarry;
  logic [DataWidth-1:0] rawRes;
  logic                 aSign, bSign;

  assign narrow = byteSel && !ctrl.forceWord;
  assign bOp    = ctrl.invSrc ? ~srcIn : srcIn;

  always_comb begin
    case (ctrl.cinSel)
      CIN_FLAG: cinBit = carryIn;
      CIN_ONE:  cinBit = 1'b1;
      default:  cinBit = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, dstIn} + {1'b0, bOp} + {{DataWidth{1'b0}}, cinBit};
  assign sumLow  = {1'b0, dstIn[Half-1:0]} + {1'b0, bOp[Half-1:0]} + {{Half{1'b0}}, cinBit};

  alu_bcd_chain #(.Digits(Digits)) uBcd (
    .aIn       (dstIn),
    .bIn       (srcIn),
    .cIn       (carryIn),
    .sumOut    (bcdSum),
    .digitCarry(bcdCarry)
  );

  always_comb begin
    case (ctrl.resSel)
      RES_SUM: rawRes = sumFull[DataWidth-1:0];
      RES_BCD: rawRes = bcdSum;
      RES_AND: rawRes = srcIn & dstIn;
      RES_BIC: rawRes = ~srcIn & dstIn;
      RES_BIS: rawRes = srcIn | dstIn;
      RES_XOR: rawRes = srcIn ^ dstIn;
      RES_SRC: rawRes = srcIn;
      RES_RRA: rawRes = narrow ? {{Half{1'b0}}, dstIn[Half-1], dstIn[Half-1:1]}
                               : {dstIn[DataWidth-1], dstIn[DataWidth-1:1]};
      RES_RRC: rawRes = narrow ? {{Half{1'b0}}, carryIn, dstIn[Half-1:1]}
                               : {carryIn, dstIn[DataWidth-1:1]};
      RES_SWP: rawRes = {dstIn[Half-1:0], dstIn[DataWidth-1:Half]};
      RES_SXT: rawRes = {{Half{dstIn[Half-1]}}, dstIn[Half-1:0]};
      default: rawRes = '0;
    endcase
  end

  assign result = narrow ? {{Half{1'b0}}, rawRes[Half-1:0]} : rawRes;

  assign nFlag = narrow ? result[Half-1] : result[DataWidth-1];
  assign zFlag = (result == '0);

  always_comb begin
    case (ctrl.cySel)
      CY_SUM:  cFlag = narrow ? sumLow[Half] : sumFull[DataWidth];
      CY_BCD:  cFlag = narrow ? bcdCarry[Digits/2-1] : bcdCarry[Digits-1];
      CY_LSB:  cFlag = dstIn[0];
      default: cFlag = !zFlag;
    endcase
  end

  assign aSign = narrow ? dstIn[Half-1] : dstIn[DataWidth-1];
  assign bSign = narrow ? bOp[Half-1]   : bOp[DataWidth-1];
  assign vFlag = ctrl.arithV && (aSign == bSign) && (nFlag != aSign);

endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_pkg::*;
#(
  parameter int DataWidth = 16
) (
  input  logic [DataWidth-1:0] srcIn,
  input  logic [DataWidth-1:0] dstIn,
  input  logic [3:0]           opSel,
  input  logic                 byteSel,
  input  logic                 carryIn,
  output logic [DataWidth-1:0] result,
  output logic                 writeEn,
  output logic                 flagEn,
  output logic                 nFlag,
  output logic                 zFlag,
  output logic                 cFlag,
  output logic                 vFlag
);

  aluCtrl_t ctrl;

  alu_ctrl uCtrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  alu_datapath #(.DataWidth(DataWidth)) uPath (
    .ctrl   (ctrl),
    .srcIn  (srcIn),
    .dstIn  (dstIn),
    .byteSel(byteSel),
    .carryIn(carryIn),
    .result (result),
    .nFlag  (nFlag),
    .zFlag  (zFlag),
    .cFlag  (cFlag),
    .vFlag  (vFlag)
  );

  assign writeEn = ctrl.writeEn;
  assign flagEn  = ctrl.flagEn;

endmodule

// File: rtl/alu_flag_core_chk.sv
module alu_flag_core_chk
  import alu_pkg::*;
#(
  parameter int DataWidth = 16
) (
  input logic [3:0]           opSel,
  input logic                 byteSel,
  input logic [DataWidth-1:0] result,
  input logic                 writeEn,
  input logic                 flagEn,
  input logic                 nFlag,
  input logic                 zFlag,
  input logic                 cFlag,
  input logic                 vFlag
);

  localparam int Half = DataWidth / 2;

  logic wordOnly, logicClass, known;

  always_comb begin
    wordOnly   = (opSel == OP_SWPB) || (opSel == OP_SXT);
    logicClass = (opSel == OP_AND) || (opSel == OP_BIT) ||
                 (opSel == OP_XOR) || (opSel == OP_SXT);
    known      = !$isunknown({opSel, byteSel, result, writeEn, flagEn,
                              nFlag, zFlag, cFlag, vFlag});
  end

  always_comb begin
    if (known) begin
      // R1
      no_write_on_test_chk: assert (writeEn == !((opSel == OP_CMP) || (opSel == OP_BIT)));
      // R11
      flag_update_set_chk: assert (flagEn == !((opSel == OP_BIC) || (opSel == OP_BIS) ||
                                               (opSel == OP_MOV) || (opSel == OP_SWPB)));
      // R7
      byte_upper_clear_chk: assert (!(byteSel && !wordOnly) || (result[DataWidth-1:Half] == '0));
      // R8
      neg_msb_chk: assert (!flagEn ||
                           (nFlag == ((byteSel && !wordOnly) ? result[Half-1] : result[DataWidth-1])));
      // R8
      zero_result_chk: assert (!flagEn || (zFlag == (result == '0)));
      // R10
      logic_flags_chk: assert (!logicClass || (!vFlag && (cFlag == !zFlag)));
    end
  end

endmodule

bind alu_flag_core alu_flag_core_chk #(.DataWidth(DataWidth)) uChk (
  .opSel  (opSel),
  .byteSel(byteSel),
  .result (result),
  .writeEn(writeEn),
  .flagEn (flagEn),
  .nFlag  (nFlag),
  .zFlag  (zFlag),
  .cFlag  (cFlag),
  .vFlag  (vFlag)
);

// File: tb/alu_flag_core_test.sv
`timescale 1ns/1ps
module alu_flag_core_test;

  typedef struct packed {
    logic [3:0]  op;
    logic        bsel;
    logic        cin;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] expRes;
    logic        expWe;
    logic        expFe;
    logic [3:0]  expNzcv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  // columns: op, byte, cin, src, dst, result, writeEn, flagEn, {N,Z,C,V}, requirement
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b1, 4'h9, 8'd9},  // R9 signed overflow
    '{4'd0,  1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 4'h6, 8'd9},  // R9 carry out
    '{4'd1,  1'b0, 1'b1, 16'h0001, 16'h0001, 16'h0003, 1'b1, 1'b1, 4'h0, 8'd2},  // R2 addc
    '{4'd2,  1'b0, 1'b0, 16'h0007, 16'h0005, 16'hFFFE, 1'b1, 1'b1, 4'h8, 8'd2},  // R2 sub borrow
    '{4'd3,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0001, 1'b1, 1'b1, 4'h2, 8'd2},  // R2 subc
    '{4'd4,  1'b0, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b1, 4'h6, 8'd1},  // R1 cmp no write
    '{4'd5,  1'b0, 1'b0, 16'h0199, 16'h0001, 16'h0200, 1'b1, 1'b1, 4'h0, 8'd3},  // R3
    '{4'd5,  1'b0, 1'b1, 16'h9999, 16'h0000, 16'h0000, 1'b1, 1'b1, 4'h6, 8'd3},  // R3 top carry
    '{4'd5,  1'b1, 1'b0, 16'h1245, 16'h3455, 16'h0000, 1'b1, 1'b1, 4'h6, 8'd3},  // R3 byte carry
    '{4'd6,  1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b1, 1'b1, 4'h2, 8'd10}, // R10
    '{4'd6,  1'b0, 1'b1, 16'hF000, 16'h0FFF, 16'h0000, 1'b1, 1'b1, 4'h4, 8'd10}, // R10 zero
    '{4'd7,  1'b0, 1'b0, 16'h8000, 16'h8001, 16'h8000, 1'b0, 1'b1, 4'hA, 8'd1},  // R1 bit no write
    '{4'd8,  1'b0, 1'b0, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 1'b0, 4'h0, 8'd4},  // R4 bic
    '{4'd9,  1'b0, 1'b0, 16'h00F0, 16'h1204, 16'h12F4, 1'b1, 1'b0, 4'h0, 8'd4},  // R4 bis
    '{4'd10, 1'b1, 1'b0, 16'hAB80, 16'hCD01, 16'h0081, 1'b1, 1'b1, 4'hA, 8'd7},  // R7 xor byte
    '{4'd11, 1'b1, 1'b0, 16'h1234, 16'hFFFF, 16'h0034, 1'b1, 1'b0, 4'h0, 8'd7},  // R7 mov byte
    '{4'd12, 1'b0, 1'b0, 16'h0000, 16'h8003, 16'hC001, 1'b1, 1'b1, 4'hA, 8'd5},  // R5 rra
    '{4'd12, 1'b1, 1'b0, 16'h0000, 16'h1281, 16'h00C0, 1'b1, 1'b1, 4'hA, 8'd5},  // R5 rra byte
    '{4'd13, 1'b0, 1'b1, 16'h0000, 16'h0002, 16'h8001, 1'b1, 1'b1, 4'h8, 8'd5},  // R5 rrc
    '{4'd13, 1'b1, 1'b0, 16'h0000, 16'hFF01, 16'h0000, 1'b1, 1'b1, 4'h6, 8'd5},  // R5 rrc byte
    '{4'd14, 1'b0, 1'b0, 16'h0000, 16'h12AB, 16'hAB12, 1'b1, 1'b0, 4'h0, 8'd6},  // R6 swpb
    '{4'd14, 1'b1, 1'b0, 16'h0000, 16'h12AB, 16'hAB12, 1'b1, 1'b0, 4'h0, 8'd6},  // R6 swpb forced word
    '{4'd15, 1'b0, 1'b0, 16'h0000, 16'h1280, 16'hFF80, 1'b1, 1'b1, 4'hA, 8'd6},  // R6 sxt
    '{4'd15, 1'b1, 1'b0, 16'h0000, 16'hFF00, 16'h0000, 1'b1, 1'b1, 4'h4, 8'd10}, // R10 sxt zero
    '{4'd0,  1'b1, 1'b0, 16'h007F, 16'h1201, 16'h0080, 1'b1, 1'b1, 4'h9, 8'd8},  // R8 byte sign
    '{4'd2,  1'b1, 1'b0, 16'hFF10, 16'h0010, 16'h0000, 1'b1, 1'b1, 4'h6, 8'd7},  // R7 sub byte
    '{4'd0,  1'b1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1, 1'b1, 4'h6, 8'd9},  // R9 byte carry
    '{4'd4,  1'b1, 1'b0, 16'h0001, 16'h0080, 16'h007F, 1'b0, 1'b1, 4'h3, 8'd9},  // R9 byte cmp V
    '{4'd5,  1'b0, 1'b1, 16'h0058, 16'h0047, 16'h0106, 1'b1, 1'b1, 4'h0, 8'd3},  // R3 digit chain
    '{4'd3,  1'b0, 1'b1, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 1'b1, 4'h3, 8'd2}   // R2 subc as sub
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] srcIn, dstIn, result;
  logic [3:0]  opSel;
  logic        byteSel, carryIn, writeEn, flagEn, nFlag, zFlag, cFlag, vFlag;

  int errors = 0;
  int checks = 0;

  alu_flag_core uut (
    .srcIn(srcIn), .dstIn(dstIn), .opSel(opSel), .byteSel(byteSel), .carryIn(carryIn),
    .result(result), .writeEn(writeEn), .flagEn(flagEn),
    .nFlag(nFlag), .zFlag(zFlag), .cFlag(cFlag), .vFlag(vFlag)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic bs, input logic ci,
                       input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    opSel = op; byteSel = bs; carryIn = ci; srcIn = s; dstIn = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    opSel = 4'd0; byteSel = 1'b0; carryIn = 1'b0; srcIn = '0; dstIn = '0;
    repeat (2) @(posedge clk);
    #1;
    // quiescent inputs: ADD of zeros, R8 zero flag set
    check("R8", "idle result", {16'h0, result}, 32'h0);
    check("R8", "idle flags", {28'h0, nFlag, zFlag, cFlag, vFlag}, 32'h4);
    check("R1", "idle writeEn", {31'h0, writeEn}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i].op, VECS[i].bsel, VECS[i].cin, VECS[i].src, VECS[i].dst);
      check(tag, $sformatf("vec%0d result", i), {16'h0, result}, {16'h0, VECS[i].expRes});
      check("R1", $sformatf("vec%0d writeEn", i), {31'h0, writeEn}, {31'h0, VECS[i].expWe});
      check("R11", $sformatf("vec%0d flagEn", i), {31'h0, flagEn}, {31'h0, VECS[i].expFe});
      if (VECS[i].expFe)
        check(tag, $sformatf("vec%0d NZCV", i), {28'h0, nFlag, zFlag, cFlag, vFlag},
              {28'h0, VECS[i].expNzcv});
    end

    // R3: every two-digit BCD pair, both carry values, byte mode with junk upper bytes
    for (int a = 0; a < 100; a++) begin
      for (int b = 0; b < 100; b++) begin
        for (int c = 0; c < 2; c++) begin
          int tot;
          logic [7:0] er;
          tot = a + b + c;
          er  = toBcd(tot % 100);
          apply(4'd5, 1'b1, c[0], {8'hA5, toBcd(b)}, {8'h3C, toBcd(a)});
          check("R3", "dadd byte result", {16'h0, result}, {24'h0, er});
          check("R3", "dadd byte NZCV", {28'h0, nFlag, zFlag, cFlag, vFlag},
                {28'h0, er[7], er == 8'h0, tot >= 100, 1'b0});
        end
      end
    end

    // R9: byte add sweep with independent carry and overflow model
    for (int s = 0; s < 256; s += 17) begin
      for (int d = 0; d < 256; d += 13) begin
        logic [8:0] sum;
        logic       ov;
        sum = 9'(s) + 9'(d);
        ov  = (s[7] == d[7]) && (sum[7] != s[7]);
        apply(4'd0, 1'b1, 1'b1, {8'hFF, 8'(s)}, {8'h80, 8'(d)});
        check("R9", "add byte result", {16'h0, result}, {24'h0, sum[7:0]});
        check("R9", "add byte NZCV", {28'h0, nFlag, zFlag, cFlag, vFlag},
              {28'h0, sum[7], sum[7:0] == 8'h0, sum[8], ov});
      end
    end

    // R2: word subtract sweep against dst - src
    for (int k = 0; k < 64; k++) begin
      logic [16:0] diff;
      logic [15:0] s, d;
      s = 16'(k * 1031);
      d = 16'(k * 2053 + 7);
      diff = {1'b0, d} + {1'b0, ~s} + 17'd1;
      apply(4'd2, 1'b0, 1'b0, s, d);
      check("R2", "sub word result", {16'h0, result}, {16'h0, diff[15:0]});
      check("R9", "sub word carry", {31'h0, cFlag}, {31'h0, diff[16]});
    end

    // R4: AND with byte select clears upper byte and sets C as NOT Z (R10)
    apply(4'd6, 1'b1, 1'b0, 16'hFFFF, 16'hFF00);
    check("R7", "and byte upper", {16'h0, result}, 32'h0);
    check("R10", "and byte flags", {28'h0, nFlag, zFlag, cFlag, vFlag}, 32'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule